// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block holds the register-level datapath of a 32-bit load/store processor in which each instruction takes several clock cycles. An external sequencer drives every select and write-enable line, one cycle at a time. The datapath returns the operation and function fields of the current instruction so that the sequencer can choose its next step. One memory port is shared by instruction fetch and data access. One adder/logic unit serves several purposes: it increments the program counter, forms branch targets and load/store addresses, and performs register arithmetic. Intermediate results are kept in holding registers from one step to the next.

The holding registers are the instruction word, the memory data word, the two operand latches and the ALU result latch. Together with a 32-entry register file and the program counter, they are the only state. The memory itself lives outside the block. It receives an address and write data, and returns read data in the same cycle.

Top module: `mcd_datapath`

## Requirements
- R1: While reset is low, the program counter and every holding register are cleared. After release, the memory address is 0 with `addr_sel`=0 and also with `addr_sel`=1, `mem_wdata` is 0, and `opcode` and `funct` are 0.
- R2: `mem_addr` equals the program counter when `addr_sel`=0 and the ALU result latch when `addr_sel`=1.
- R3: The instruction word loads `mem_rdata` only on an edge where `ir_wr`=1, and otherwise holds. `opcode` is instruction bits 31:26 and `funct` is bits 5:0.
- R4: On every edge, operand latch A loads the register indexed by instruction bits 25:21 and latch B loads the register indexed by bits 20:16. `mem_wdata` is latch B.
- R5: The memory data latch loads `mem_rdata` on every edge. When `rf_wr`=1, the register file writes register bits 15:11 if `dst_sel`=1, and bits 20:16 if `dst_sel`=0. The value written is the memory data latch if `wb_sel`=1 and the ALU result latch if `wb_sel`=0.
- R6: The ALU result latch loads the ALU output on every edge. `alu_op`=00 adds and 01 subtracts. With 10, `funct` selects the operation: 32 add, 34 subtract, 36 AND, 37 OR, 42 signed set-less-than. Any other funct code gives 0.
- R7: The first ALU input is the program counter when `srca_sel`=0 and latch A when `srca_sel`=1. The second ALU input depends on `srcb_sel`: 00 gives latch B, 01 the constant 4, 10 the sign-extended bits 15:0, and 11 that value shifted left by 2.
- R8: The next program counter is chosen by `pc_src`: 00 (and 11) the ALU output, 01 the ALU result latch, and 10 the jump target. The jump target is the upper 4 bits of the program counter, then instruction bits 25:0, then two zero bits.
- R9: The program counter is written when `pc_wr`=1, or when `pc_wr_cond`=1 and the ALU output is zero. Otherwise it holds its value.
- R10: Register 0 always reads as zero, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_wr | input | 1 | Unconditional program counter write |
| pc_wr_cond | input | 1 | Program counter write when ALU output is zero |
| ir_wr | input | 1 | Instruction word load enable |
| addr_sel | input | 1 | Memory address select: 0 program counter, 1 ALU result latch |
| rf_wr | input | 1 | Register file write enable |
| dst_sel | input | 1 | Destination register field select |
| wb_sel | input | 1 | Write-back data select |
| srca_sel | input | 1 | First ALU input select |
| srcb_sel | input | 2 | Second ALU input select |
| alu_op | input | 2 | ALU operation class |
| pc_src | input | 2 | Next program counter source |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data (latch B) |
| opcode | output | 6 | Instruction bits 31:26 |
| funct | output | 6 | Instruction bits 5:0 |

## Verification
Every holding register and the program counter change at the single rising edge that ends the cycle in which their controls were driven. The bench therefore drives controls at a falling edge and reads the results at the next falling edge, before the next rising edge can overwrite the unconditionally loaded latches.

A register-file write becomes visible two edges later. It commits at the write-back edge, and latch B loads it at the decode edge of a later instruction, so register contents are read through `mem_wdata` after that decode edge. The ALU result latch and the program counter are both read from `mem_addr`, by switching `addr_sel` in the low half of the clock.

// File: rtl/mcd_pkg.sv
package mcd_pkg;
   localparam logic [1:0] AOP_ADD   = 2'b00;
   localparam logic [1:0] AOP_SUB   = 2'b01;
   localparam logic [1:0] AOP_FUNCT = 2'b10;

   localparam logic [5:0] FC_ADD = 6'd32;
   localparam logic [5:0] FC_SUB = 6'd34;
   localparam logic [5:0] FC_AND = 6'd36;
   localparam logic [5:0] FC_OR  = 6'd37;
   localparam logic [5:0] FC_SLT = 6'd42;

   localparam logic [1:0] SRCB_REG  = 2'b00;
   localparam logic [1:0] SRCB_FOUR = 2'b01;
   localparam logic [1:0] SRCB_IMM  = 2'b10;
   localparam logic [1:0] SRCB_IMM4 = 2'b11;

   localparam logic [1:0] PCS_ALU   = 2'b00;
   localparam logic [1:0] PCS_LATCH = 2'b01;
   localparam logic [1:0] PCS_JUMP  = 2'b10;

   typedef enum logic [2:0] {
      ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT, ALU_NONE
   } alu_fn_e;

   function automatic alu_fn_e decode_alu(input logic [1:0] op, input logic [5:0] fc);
      alu_fn_e r;
      r = ALU_NONE;
      case (op)
         AOP_ADD: r = ALU_ADD;
         AOP_SUB: r = ALU_SUB;
         AOP_FUNCT: begin
            case (fc)
               FC_ADD:  r = ALU_ADD;
               FC_SUB:  r = ALU_SUB;
               FC_AND:  r = ALU_AND;
               FC_OR:   r = ALU_OR;
               FC_SLT:  r = ALU_SLT;
               default: r = ALU_NONE;
            endcase
         end
         default: r = ALU_NONE;
      endcase
      return r;
   endfunction
endpackage

// File: rtl/mcd_alu.sv
module mcd_alu
   import mcd_pkg::*;
#(
   parameter int W          = 32,
   parameter bit SLT_SIGNED = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [1:0]   op,
   input  logic [5:0]   fc,
   output logic [W-1:0] y,
   output logic         zero
);
   alu_fn_e fn;
   logic    lt;

   assign fn = decode_alu(op, fc);

   generate
      if (SLT_SIGNED) begin : g_slt_s
         assign lt = $signed(a) < $signed(b);
      end else begin : g_slt_u
         assign lt = a < b;
      end
   endgenerate

   always_comb begin
      case (fn)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SLT: y = {{(W-1){1'b0}}, lt};
         default: y = '0;
      endcase
   end

   assign zero = (y == '0);
endmodule

// File: rtl/mcd_regfile.sv
module mcd_regfile #(
   parameter int W        = 32,
   parameter int NREG     = 32,
   parameter int RAW      = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [RAW-1:0] ra_a,
   input  logic [RAW-1:0] ra_b,
   input  logic [RAW-1:0] wa,
   input  logic           we,
   input  logic [W-1:0]   wd,
   output logic [W-1:0]   rd_a,
   output logic [W-1:0]   rd_b
);
   logic [W-1:0] regs [NREG];
   logic         wr_ok;

   generate
      if (ZERO_REG) begin : g_zero
         assign wr_ok = we && (wa != '0);
         assign rd_a  = (ra_a == '0) ? '0 : regs[ra_a];
         assign rd_b  = (ra_b == '0) ? '0 : regs[ra_b];
      end else begin : g_flat
         assign wr_ok = we;
         assign rd_a  = regs[ra_a];
         assign rd_b  = regs[ra_b];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= '0;
      end else if (wr_ok) begin
         regs[wa] <= wd;
      end
   end
endmodule

// File: rtl/mcd_datapath.sv
module mcd_datapath
   import mcd_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter int          NREG       = 32,
   parameter bit          ZERO_REG   = 1'b1,
   parameter bit          SLT_SIGNED = 1'b1,
   parameter logic [31:0] PC_RESET   = 32'h0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_wr,
   input  logic            pc_wr_cond,
   input  logic            ir_wr,
   input  logic            addr_sel,
   input  logic            rf_wr,
   input  logic            dst_sel,
   input  logic            wb_sel,
   input  logic            srca_sel,
   input  logic [1:0]      srcb_sel,
   input  logic [1:0]      alu_op,
   input  logic [1:0]      pc_src,
   input  logic [XLEN-1:0] mem_rdata,
   output logic [XLEN-1:0] mem_addr,
   output logic [XLEN-1:0] mem_wdata,
   output logic [5:0]      opcode,
   output logic [5:0]      funct
);
   localparam int RAW    = (NREG > 1) ? $clog2(NREG) : 1;
   localparam int IMM_W  = 16;
   localparam int EXT_W  = XLEN - IMM_W;
   localparam int RS_LSB = 21;
   localparam int RT_LSB = 16;
   localparam int RD_LSB = 11;

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("mcd_datapath: instruction fields require XLEN of 32");
      end
      if (NREG < 2 || NREG > 32 || (1 << RAW) != NREG) begin : g_bad_nreg
         $error("mcd_datapath: NREG must be a power of two from 2 to 32");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, aluout_q;
   logic [XLEN-1:0] rf_a, rf_b, alu_a, alu_b, alu_y, pc_next, imm_sx, jmp_tgt, wb_data;
   logic [RAW-1:0]  wb_idx;
   logic            alu_zero, pc_en;

   assign imm_sx  = {{EXT_W{ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
   assign jmp_tgt = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};

   assign mem_addr  = addr_sel ? aluout_q : pc_q;
   assign mem_wdata = b_q;
   assign opcode    = ir_q[31:26];
   assign funct     = ir_q[5:0];

   assign wb_idx  = dst_sel ? ir_q[RD_LSB +: RAW] : ir_q[RT_LSB +: RAW];
   assign wb_data = wb_sel ? mdr_q : aluout_q;

   mcd_regfile #(
      .W(XLEN), .NREG(NREG), .RAW(RAW), .ZERO_REG(ZERO_REG)
   ) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ra_a(ir_q[RS_LSB +: RAW]), .ra_b(ir_q[RT_LSB +: RAW]),
      .wa(wb_idx), .we(rf_wr), .wd(wb_data),
      .rd_a(rf_a), .rd_b(rf_b)
   );

   assign alu_a = srca_sel ? a_q : pc_q;

   always_comb begin
      case (srcb_sel)
         SRCB_REG:  alu_b = b_q;
         SRCB_FOUR: alu_b = XLEN'(4);
         SRCB_IMM:  alu_b = imm_sx;
         default:   alu_b = {imm_sx[XLEN-3:0], 2'b00};
      endcase
   end

   mcd_alu #(.W(XLEN), .SLT_SIGNED(SLT_SIGNED)) u_alu (
      .a(alu_a), .b(alu_b), .op(alu_op), .fc(ir_q[5:0]),
      .y(alu_y), .zero(alu_zero)
   );

   always_comb begin
      case (pc_src)
         PCS_LATCH: pc_next = aluout_q;
         PCS_JUMP:  pc_next = jmp_tgt;
         default:   pc_next = alu_y;
      endcase
   end

   assign pc_en = pc_wr | (pc_wr_cond & alu_zero);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_q     <= PC_RESET;
         ir_q     <= '0;
         mdr_q    <= '0;
         a_q      <= '0;
         b_q      <= '0;
         aluout_q <= '0;
      end else begin
         mdr_q    <= mem_rdata;
         a_q      <= rf_a;
         b_q      <= rf_b;
         aluout_q <= alu_y;
         if (ir_wr) ir_q <= mem_rdata;
         if (pc_en) pc_q <= pc_next;
      end
   end
endmodule

// File: rtl/mcd_datapath_chk.sv
module mcd_datapath_chk #(
   parameter int XLEN     = 32,
   parameter int RAW      = 5,
   parameter bit ZERO_REG = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            pc_wr,
   input logic            pc_wr_cond,
   input logic            ir_wr,
   input logic            srca_sel,
   input logic [1:0]      srcb_sel,
   input logic [1:0]      alu_op,
   input logic [1:0]      pc_src,
   input logic            alu_zero,
   input logic [XLEN-1:0] mem_rdata,
   input logic [XLEN-1:0] pc_q,
   input logic [XLEN-1:0] ir_q,
   input logic [XLEN-1:0] a_q,
   input logic [XLEN-1:0] mdr_q
);
   // R3: instruction word captures read data only under its enable
   a_r3_ir_load: assert property (@(posedge clk) disable iff (!rst_n)
      ir_wr |=> ir_q == $past(mem_rdata));
   a_r3_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ir_wr |=> $stable(ir_q));

   // R5: memory data latch follows read data every edge
   a_r5_mdr_follow: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> mdr_q == $past(mem_rdata));

   // R7: fetch-style increment advances the program counter by 4
   a_r7_pc_inc: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && !srca_sel && srcb_sel == 2'b01 && alu_op == 2'b00 && pc_src == 2'b00)
      |=> pc_q == $past(pc_q) + XLEN'(4));

   // R8: jump keeps the upper four bits and word-aligns
   a_r8_jump_form: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_wr && pc_src == 2'b10)
      |=> (pc_q[1:0] == 2'b00) && (pc_q[XLEN-1:XLEN-4] == $past(pc_q[XLEN-1:XLEN-4])));

   // R9: program counter holds without a qualifying write
   a_r9_pc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_wr && !(pc_wr_cond && alu_zero)) |=> $stable(pc_q));

   generate
      if (ZERO_REG) begin : g_r0
         // R10: register 0 always reads zero into latch A
         a_r10_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
            (ir_q[21 +: RAW] == '0) |=> a_q == '0);
      end
   endgenerate
endmodule

bind mcd_datapath mcd_datapath_chk #(
   .XLEN(XLEN), .RAW(RAW), .ZERO_REG(ZERO_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
   .ir_wr(ir_wr), .srca_sel(srca_sel), .srcb_sel(srcb_sel), .alu_op(alu_op),
   .pc_src(pc_src), .alu_zero(alu_zero), .mem_rdata(mem_rdata),
   .pc_q(pc_q), .ir_q(ir_q), .a_q(a_q), .mdr_q(mdr_q)
);

// File: tb/mcd_datapath_test.sv
module mcd_datapath_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pc_wr, pc_wr_cond, ir_wr, addr_sel, rf_wr, dst_sel, wb_sel, srca_sel;
   logic [1:0]  srcb_sel, alu_op, pc_src;
   logic [31:0] mem_rdata, mem_addr, mem_wdata;
   logic [5:0]  opcode, funct;

   logic [31:0] mem [64];
   logic [31:0] rm  [32];
   logic [31:0] exp_pc;
   int n_vec  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[7:2]];

   mcd_datapath uut (
      .clk(clk), .rst_n(rst_n), .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond),
      .ir_wr(ir_wr), .addr_sel(addr_sel), .rf_wr(rf_wr), .dst_sel(dst_sel),
      .wb_sel(wb_sel), .srca_sel(srca_sel), .srcb_sel(srcb_sel),
      .alu_op(alu_op), .pc_src(pc_src), .mem_rdata(mem_rdata),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .opcode(opcode), .funct(funct)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fc);
      return {6'd0, rs[4:0], rt[4:0], rd[4:0], 5'd0, fc[5:0]};
   endfunction

   function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
      return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
   endfunction

   function automatic logic [31:0] sx(input int imm);
      return {{16{imm[15]}}, imm[15:0]};
   endfunction

   function automatic logic [31:0] alu_model(input logic [31:0] a, input logic [31:0] b, input int fc);
      case (fc)
         32:      return a + b;
         34:      return a - b;
         36:      return a & b;
         37:      return a | b;
         42:      return {31'd0, $signed(a) < $signed(b)};
         default: return 32'd0;
      endcase
   endfunction

   task automatic ctl_clear();
      pc_wr = 0; pc_wr_cond = 0; ir_wr = 0; addr_sel = 0; rf_wr = 0;
      dst_sel = 0; wb_sel = 0; srca_sel = 0; srcb_sel = 0; alu_op = 0; pc_src = 0;
   endtask

   task automatic run_edge();
      @(posedge clk);
      @(negedge clk);
      ctl_clear();
   endtask

   task automatic peek_pc(output logic [31:0] v);
      addr_sel = 1'b0; #1; v = mem_addr;
   endtask

   task automatic peek_alu(output logic [31:0] v);
      addr_sel = 1'b1; #1; v = mem_addr; addr_sel = 1'b0; #1;
   endtask

   task automatic ph_fetch(input logic [31:0] instr);
      logic [31:0] v;
      mem[exp_pc[7:2]] = instr;
      ir_wr = 1; srcb_sel = 2'b01; pc_wr = 1;
      run_edge();
      exp_pc = exp_pc + 4;
      peek_pc(v);
      chk("R9 pc after fetch increment", v, exp_pc);
      chk("R3 opcode after load", {26'd0, opcode}, {26'd0, instr[31:26]});
   endtask

   task automatic ph_decode();
      srcb_sel = 2'b11;
      run_edge();
   endtask

   task automatic do_lw(input int rs, input int rt, input int imm);
      logic [31:0] v, ea;
      ph_fetch(enc_i(35, rs, rt, imm));
      ph_decode();
      srca_sel = 1; srcb_sel = 2'b10;
      run_edge();
      ea = rm[rs] + sx(imm);
      peek_alu(v);
      chk("R7 load address A plus sign-extended offset (R2 addr_sel=1)", v, ea);
      addr_sel = 1;
      run_edge();
      wb_sel = 1; rf_wr = 1;
      run_edge();
      if (rt != 0) rm[rt] = mem[ea[7:2]];
   endtask

   task automatic do_r(input int rs, input int rt, input int rd, input int fc);
      logic [31:0] v, res;
      ph_fetch(enc_r(rs, rt, rd, fc));
      chk("R3 funct field", {26'd0, funct}, fc);
      ph_decode();
      chk("R4 latch B shows rt register (R5 prior write-back)", mem_wdata, rm[rt]);
      srca_sel = 1; srcb_sel = 2'b00; alu_op = 2'b10;
      run_edge();
      res = alu_model(rm[rs], rm[rt], fc);
      peek_alu(v);
      chk($sformatf("R6 funct %0d result", fc), v, res);
      dst_sel = 1; rf_wr = 1;
      run_edge();
      if (rd != 0) rm[rd] = res;
   endtask

   task automatic do_sw(input int rs, input int rt, input int imm);
      logic [31:0] ea;
      ph_fetch(enc_i(43, rs, rt, imm));
      ph_decode();
      chk("R4 store data from B (R10 when rt is 0)", mem_wdata, rm[rt]);
      srca_sel = 1; srcb_sel = 2'b10;
      run_edge();
      ea = rm[rs] + sx(imm);
      addr_sel = 1; #1;
      chk("R2 store address on port", mem_addr, ea);
      mem[ea[7:2]] = mem_wdata;
      run_edge();
      chk("R4 stored word", mem[ea[7:2]], rm[rt]);
   endtask

   task automatic do_beq(input int rs, input int rt, input int off);
      logic [31:0] v, pc4, tgt;
      ph_fetch(enc_i(4, rs, rt, off));
      pc4 = exp_pc;
      ph_decode();
      tgt = pc4 + (sx(off) << 2);
      peek_alu(v);
      chk("R7 branch target PC plus offset times 4", v, tgt);
      srca_sel = 1; alu_op = 2'b01; pc_wr_cond = 1; pc_src = 2'b01;
      run_edge();
      exp_pc = (rm[rs] == rm[rt]) ? tgt : pc4;
      peek_pc(v);
      chk("R9 conditional write (R8 pc_src=01)", v, exp_pc);
   endtask

   task automatic do_j(input int tgt26);
      logic [31:0] v;
      ph_fetch({6'd2, tgt26[25:0]});
      pc_wr = 1; pc_src = 2'b10;
      run_edge();
      exp_pc = {exp_pc[31:28], tgt26[25:0], 2'b00};
      peek_pc(v);
      chk("R8 jump target", v, exp_pc);
      mem[exp_pc[7:2]] = enc_r(1, 1, 1, 32);
      run_edge();
      chk("R3 opcode held without ir_wr", {26'd0, opcode}, 32'd2);
      peek_pc(v);
      chk("R9 pc holds without write", v, exp_pc);
   endtask

   task automatic do_reset();
      logic [31:0] v;
      rst_n = 1'b0;
      ctl_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      exp_pc = 32'd0;
      for (int i = 0; i < 32; i++) rm[i] = 32'd0;
      peek_pc(v);
      chk("R1 pc cleared", v, 32'd0);
      peek_alu(v);
      chk("R1 ALU result latch cleared", v, 32'd0);
      chk("R1 latch B cleared", mem_wdata, 32'd0);
      chk("R1 opcode/funct cleared", {20'd0, opcode, funct}, 32'd0);
   endtask

   initial begin : watchdog
      #1500000;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec + 1, n_fail + 1);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < 64; i++) mem[i] = 32'd0;
      mem[40] = 32'd100;
      mem[41] = 32'hFFFF_FFF0;
      mem[42] = 32'h0F0F_00FF;
      ctl_clear();
      @(negedge clk);
      do_reset();
      do_lw(0, 1, 160);
      do_lw(0, 2, 164);
      do_lw(1, 3, 68);
      do_r(1, 2, 4, 32);
      do_r(1, 2, 5, 34);
      do_r(3, 2, 6, 36);
      do_r(1, 2, 7, 37);
      do_r(2, 1, 8, 42);
      do_r(1, 2, 9, 42);
      do_r(1, 2, 10, 39);
      do_sw(0, 4, 176);
      do_sw(3, 5, -132);
      do_r(1, 1, 0, 32);
      do_sw(0, 0, 180);
      do_r(0, 6, 11, 37);
      do_beq(1, 1, 2);
      do_beq(1, 2, 5);
      do_beq(9, 0, -1);
      do_j(4);
      do_lw(0, 12, 176);
      do_r(0, 12, 13, 32);
      do_reset();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end
endmodule